// File: doc/BRIEF.md
# Event-to-Virtual-Interrupt Aggregator

This block collects event messages from many sources and funnels them into a small set of virtual interrupt groups. Each group is a 64-slot pending word with its own enable mask and one interrupt line. Every message carries a 16-bit global event number and an up/down flag. A programmable routing table turns the global event number into a (group, slot) pair. An up message marks that slot pending. A down message clears it, so level-type sources retire themselves without software. Edge-type sources stay pending until software writes a one to the slot in the status register.

Software sees one register window per group. Window `g` starts at byte address `g * 0x1000`. Inside a window, enables are set by a write-one-to-set register and cleared by a write-one-to-clear register. Status is read as a full 64-bit word and is acknowledged by writing ones. A separate configuration port loads the routing table. A group's interrupt line is high while any slot is both pending and enabled.

Top module: `evagg_top`

## Requirements
- R1: After reset, every enable bit and every status bit is 0, every interrupt line is low, the drop flag `evt_err` is 0, and every routing entry is invalid, so an event sent before any configuration is dropped.
- R2: A register write at window offset 0x000 sets each enable bit whose `reg_wdata` bit is 1. Enable bits whose data bit is 0 keep their value.
- R3: A register write at window offset 0x008 clears each enable bit whose `reg_wdata` bit is 1. Enable bits whose data bit is 0 keep their value.
- R4: Offset 0x018 reads the group's 64-bit pending word. A write there clears each pending bit whose data bit is 1 and leaves the other bits unchanged.
- R5: An accepted up message for global event `e`, with a valid entry `e` routing to (group `g`, slot `b`), sets pending bit `b` of group `g` on the next clock edge. No other bit changes. `evt_ready` is always 1.
- R6: An accepted down message for a mapped event clears its routed pending bit on the next clock edge, with no software write.
- R7: Interrupt line `vint_irq[g]` is 1 exactly when group `g` has at least one bit that is both pending and enabled.
- R8: A message is dropped if its event number is 256 or above, or if its routing entry is invalid. A dropped message changes no pending bit and sets `evt_err`. `evt_err` stays set until reset.
- R9: If an up message and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: Reads at offsets 0x000 and 0x008 both return the enable mask. Reads at any other offset, other than 0x018, return 0. Writes to those other offsets have no effect.
- R11: A configuration write (`cfg_we` with `cfg_idx`, `cfg_valid`, `cfg_grp`, `cfg_bit`) replaces one routing entry from the next cycle on. Writing an entry with `cfg_valid=0` makes later messages for that event drop. A message in the same cycle as the configuration write uses the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event message valid |
| evt_ready | output | 1 | Event message accepted (always 1) |
| evt_gid | input | 16 | Global event number |
| evt_up | input | 1 | 1 = up (set), 0 = down (clear) |
| evt_err | output | 1 | Sticky flag: a message was dropped |
| cfg_we | input | 1 | Routing table write strobe |
| cfg_idx | input | 8 | Routing entry index (global event number) |
| cfg_valid | input | 1 | Valid bit written into the entry |
| cfg_grp | input | 2 | Target group written into the entry |
| cfg_bit | input | 6 | Target slot written into the entry |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 14 | Byte address: group in [13:12], offset in [11:0] |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Combinational read data for `reg_addr` |
| vint_irq | output | 4 | One interrupt line per group |

## Verification
The bench goes after these corner cases:

- An event number whose low eight bits match a valid entry but which is out of range. An aliasing index decoder would set a pending bit instead of raising the drop flag.
- An up message that coincides with an acknowledge of the same slot. A design that lets the clear win would lose that event.
- Configuration writes in the same cycle as a message, and entries rewritten or invalidated. These expose a design that routes with a stale or a premature entry.
- Long random mixes of both message kinds, partial enable masks and writes to unused offsets. These catch set/clear masks applied to the wrong bits or group windows decoded off by one.

// File: rtl/evagg_pkg.sv
package evagg_pkg;

  localparam int WIN_SHIFT = 12;

  localparam logic [WIN_SHIFT-1:0] OFF_EN_SET = 12'h000;
  localparam logic [WIN_SHIFT-1:0] OFF_EN_CLR = 12'h008;
  localparam logic [WIN_SHIFT-1:0] OFF_STATUS = 12'h018;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_EN_SET,
    RK_EN_CLR,
    RK_STATUS
  } reg_kind_e;

  // decode of a byte offset inside one group window
  function automatic reg_kind_e off_kind(input logic [WIN_SHIFT-1:0] off);
    case (off)
      OFF_EN_SET: return RK_EN_SET;
      OFF_EN_CLR: return RK_EN_CLR;
      OFF_STATUS: return RK_STATUS;
      default:    return RK_NONE;
    endcase
  endfunction

  // next pending word: software clear first, then events on top
  function automatic logic [63:0] next_pending(input logic [63:0] cur,
                                               input logic [63:0] clr,
                                               input logic [63:0] up,
                                               input logic [63:0] dn);
    return (cur & ~clr & ~dn) | up;
  endfunction

endpackage

// File: rtl/evagg_map_table.sv
module evagg_map_table #(
  parameter int DEPTH = 256,
  parameter int GID_W = 16,
  parameter int GRP_W = 2,
  parameter int BIT_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [GRP_W-1:0] wr_grp,
  input  logic [BIT_W-1:0] wr_bit,
  input  logic [GID_W-1:0] look_gid,
  output logic             look_hit,
  output logic [GRP_W-1:0] look_grp,
  output logic [BIT_W-1:0] look_bit
);

  logic             vld_q [DEPTH];
  logic [GRP_W-1:0] grp_q [DEPTH];
  logic [BIT_W-1:0] bit_q [DEPTH];

  logic             in_range;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i] <= 1'b0;
        grp_q[i] <= '0;
        bit_q[i] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_idx] <= wr_valid;
      grp_q[wr_idx] <= wr_grp;
      bit_q[wr_idx] <= wr_bit;
    end
  end

  assign in_range = (32'(look_gid) < DEPTH);
  assign idx      = look_gid[IDX_W-1:0];
  assign look_hit = in_range && vld_q[idx];
  assign look_grp = grp_q[idx];
  assign look_bit = bit_q[idx];

  // R8: an out-of-range number never hits, whatever its low bits are
  AST_RANGE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(look_gid) >= DEPTH) |-> !look_hit); // R8

  // R11: a table write is visible on the next cycle
  AST_CFG_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (look_gid == GID_W'(wr_idx))) |=> (look_hit == $past(wr_valid))); // R11

endmodule

// File: rtl/evagg_group.sv
module evagg_group
  import evagg_pkg::*;
#(
  parameter int BITS = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_set_we,
  input  logic            en_clr_we,
  input  logic            st_clr_we,
  input  logic [BITS-1:0] wdata,
  input  logic [BITS-1:0] up_vec,
  input  logic [BITS-1:0] dn_vec,
  output logic [BITS-1:0] enable_o,
  output logic [BITS-1:0] status_o,
  output logic            irq_o
);

  logic [BITS-1:0] en_q, st_q;
  logic [BITS-1:0] clr_vec;

  assign clr_vec = st_clr_we ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_set_we)      en_q <= en_q | wdata;
      else if (en_clr_we) en_q <= en_q & ~wdata;
      st_q <= next_pending(st_q, clr_vec, up_vec, dn_vec);
    end
  end

  assign enable_o = en_q;
  assign status_o = st_q;
  assign irq_o    = |(st_q & en_q);

  AST_W1S: assert property (@(posedge clk) disable iff (!rst_n)
    en_set_we |=> ((en_q & $past(wdata)) == $past(wdata))); // R2

  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_we && !en_set_we) |=> ((en_q & $past(wdata)) == '0)); // R3

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set_we && !en_clr_we) |=> $stable(en_q)); // R10

  AST_ST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    st_clr_we |=> ((st_q & $past(wdata & ~up_vec)) == '0)); // R4

  AST_UP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (up_vec != '0) |=> ((st_q & $past(up_vec)) == $past(up_vec))); // R5

  AST_DOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_vec != '0) |=> ((st_q & $past(dn_vec)) == '0)); // R6

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_we && ((wdata & up_vec) != '0)) |=> ((st_q & $past(up_vec)) != '0)); // R9

  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_clr_we && up_vec == '0 && dn_vec == '0) |=> $stable(st_q)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0 && st_q != '0)); // R7

  AST_ONE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(up_vec | dn_vec) <= 1); // R5

endmodule

// File: rtl/evagg_top.sv
module evagg_top
  import evagg_pkg::*;
#(
  parameter int NUM_GRP   = 4,
  parameter int BITS      = 64,
  parameter int MAP_DEPTH = 256,
  parameter int GID_W     = 16,
  localparam int GRP_W  = $clog2(NUM_GRP),
  localparam int BIT_W  = $clog2(BITS),
  localparam int IDX_W  = $clog2(MAP_DEPTH),
  localparam int ADDR_W = GRP_W + WIN_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  output logic              evt_ready,
  input  logic [GID_W-1:0]  evt_gid,
  input  logic              evt_up,
  output logic              evt_err,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [GRP_W-1:0]  cfg_grp,
  input  logic [BIT_W-1:0]  cfg_bit,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BITS-1:0]   reg_wdata,
  output logic [BITS-1:0]   reg_rdata,
  output logic [NUM_GRP-1:0] vint_irq
);

  logic             evt_fire;
  logic             map_hit;
  logic [GRP_W-1:0] map_grp;
  logic [BIT_W-1:0] map_bit;
  logic [BITS-1:0]  slot_vec;
  logic             drop_now;
  logic             err_q;

  logic [GRP_W-1:0]     sel_grp;
  reg_kind_e            sel_kind;
  logic [BITS-1:0]      en_all [NUM_GRP];
  logic [BITS-1:0]      st_all [NUM_GRP];
  logic [NUM_GRP*BITS-1:0] st_flat;

  assign evt_ready = 1'b1;
  assign evt_fire  = evt_valid && evt_ready;

  evagg_map_table #(
    .DEPTH(MAP_DEPTH), .GID_W(GID_W), .GRP_W(GRP_W), .BIT_W(BIT_W)
  ) map_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_valid(cfg_valid),
    .wr_grp(cfg_grp), .wr_bit(cfg_bit),
    .look_gid(evt_gid), .look_hit(map_hit),
    .look_grp(map_grp), .look_bit(map_bit)
  );

  assign slot_vec = BITS'(1) << map_bit;
  assign drop_now = evt_fire && !map_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        err_q <= 1'b0;
    else if (drop_now) err_q <= 1'b1;
  end
  assign evt_err = err_q;

  assign sel_grp  = reg_addr[ADDR_W-1:WIN_SHIFT];
  assign sel_kind = off_kind(reg_addr[WIN_SHIFT-1:0]);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic            here, hit_here;
    logic [BITS-1:0] up_v, dn_v;

    assign here     = reg_we && (sel_grp == GRP_W'(g));
    assign hit_here = evt_fire && map_hit && (map_grp == GRP_W'(g));
    assign up_v     = (hit_here &&  evt_up) ? slot_vec : '0;
    assign dn_v     = (hit_here && !evt_up) ? slot_vec : '0;

    evagg_group #(.BITS(BITS)) grp_i (
      .clk(clk), .rst_n(rst_n),
      .en_set_we(here && sel_kind == RK_EN_SET),
      .en_clr_we(here && sel_kind == RK_EN_CLR),
      .st_clr_we(here && sel_kind == RK_STATUS),
      .wdata(reg_wdata),
      .up_vec(up_v), .dn_vec(dn_v),
      .enable_o(en_all[g]), .status_o(st_all[g]),
      .irq_o(vint_irq[g])
    );

    assign st_flat[g*BITS +: BITS] = st_all[g];
  end

  always_comb begin
    case (sel_kind)
      RK_EN_SET, RK_EN_CLR: reg_rdata = en_all[sel_grp];
      RK_STATUS:            reg_rdata = st_all[sel_grp];
      default:              reg_rdata = '0;
    endcase
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |=> evt_err); // R8

  AST_DROP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    drop_now |=> evt_err); // R8

  AST_DROP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_now && !reg_we) |=> $stable(st_flat)); // R8

  AST_UNUSED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_kind == RK_NONE) |-> (reg_rdata == '0)); // R10

  AST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> evt_ready); // R5

endmodule

// File: tb/evagg_top_tb_top.sv
module evagg_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic        evt_ready;
  logic [15:0] evt_gid = '0;
  logic        evt_up = 1'b0;
  logic        evt_err;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_idx = '0;
  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_grp = '0;
  logic [5:0]  cfg_bit = '0;
  logic        reg_we = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [3:0]  vint_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_en [NG];
  logic [63:0] m_st [NG];
  logic        m_v  [256];
  logic [1:0]  m_g  [256];
  logic [5:0]  m_b  [256];
  logic        m_err;

  evagg_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_gid(evt_gid),
    .evt_up(evt_up), .evt_err(evt_err),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid),
    .cfg_grp(cfg_grp), .cfg_bit(cfg_bit),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .vint_irq(vint_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] exp_read(input int g, input logic [11:0] off);
    if (off == 12'h000 || off == 12'h008) return m_en[g];
    if (off == 12'h018) return m_st[g];
    return 64'h0;
  endfunction

  function automatic logic exp_irq(input int g);
    return (m_st[g] & m_en[g]) != 64'h0;
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NG; g++) begin m_en[g] = '0; m_st[g] = '0; end
    for (int i = 0; i < 256; i++) begin m_v[i] = 0; m_g[i] = 0; m_b[i] = 0; end
    m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: optional message, register write, table write
  task automatic step(input bit ev, input logic [15:0] gid, input bit up,
                      input bit we, input logic [13:0] addr, input logic [63:0] wd,
                      input bit cw, input logic [7:0] ci, input bit cv,
                      input logic [1:0] cg, input logic [5:0] cb);
    int g;
    logic [11:0] off;
    evt_valid = ev; evt_gid = gid; evt_up = up;
    reg_we = we; reg_addr = addr; reg_wdata = wd;
    cfg_we = cw; cfg_idx = ci; cfg_valid = cv; cfg_grp = cg; cfg_bit = cb;
    @(posedge clk);
    g = int'(addr[13:12]);
    off = addr[11:0];
    if (we) begin
      if (off == 12'h000)      m_en[g] = m_en[g] | wd;
      else if (off == 12'h008) m_en[g] = m_en[g] & ~wd;
      else if (off == 12'h018) m_st[g] = m_st[g] & ~wd;
    end
    if (ev) begin
      if (gid < 16'd256 && m_v[gid[7:0]]) begin
        if (up) m_st[m_g[gid[7:0]]][m_b[gid[7:0]]] = 1'b1;
        else    m_st[m_g[gid[7:0]]][m_b[gid[7:0]]] = 1'b0;
      end else begin
        m_err = 1'b1;
      end
    end
    if (cw) begin m_v[ci] = cv; m_g[ci] = cg; m_b[ci] = cb; end
    @(negedge clk);
    evt_valid = 0; reg_we = 0; cfg_we = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic cfg(input logic [7:0] i, input bit v, input logic [1:0] g, input logic [5:0] b);
    step(0, 0, 0, 0, 0, 0, 1, i, v, g, b);
  endtask

  task automatic evt(input logic [15:0] gid, input bit up);
    step(1, gid, up, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic wr(input int g, input logic [11:0] off, input logic [63:0] d);
    step(0, 0, 0, 1, {g[1:0], off}, d, 0, 0, 0, 0, 0);
  endtask

  task automatic chk_all(input string tag);
    logic [11:0] offs [5];
    offs[0] = 12'h000; offs[1] = 12'h008; offs[2] = 12'h018;
    offs[3] = 12'h010; offs[4] = 12'h020;
    for (int g = 0; g < NG; g++) begin
      for (int k = 0; k < 5; k++) begin
        reg_addr = {g[1:0], offs[k]};
        #1;
        check($sformatf("%s g%0d off=%h", tag, g, offs[k]), reg_rdata, exp_read(g, offs[k]));
      end
      check($sformatf("%s irq g%0d R7", tag, g), {63'h0, vint_irq[g]}, {63'h0, exp_irq(g)});
    end
    check($sformatf("%s err R8", tag), {63'h0, evt_err}, {63'h0, m_err});
    check($sformatf("%s ready R5", tag), {63'h0, evt_ready}, 64'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    do_reset();
    chk_all("R1 reset");

    // R1: table empty after reset, so a message drops
    evt(16'd7, 1);
    chk_all("R1 empty table drop");
    do_reset();
    chk_all("R1 second reset");

    // R8: out-of-range number aliasing a valid entry is dropped
    cfg(8'd7, 1, 2'd2, 6'd63);
    evt(16'd263, 1);
    chk_all("R8 out of range");
    do_reset();

    // R5: routed up message sets only its slot
    cfg(8'd7, 1, 2'd2, 6'd63);
    evt(16'd7, 1);
    chk_all("R5 up sets slot");
    // R2 / R7: enable raises the line
    wr(2, 12'h000, 64'h8000_0000_0000_0001);
    chk_all("R2 enable set");
    wr(2, 12'h000, 64'h0);
    chk_all("R2 zero write keeps");
    // R3: clear enable drops the line
    wr(2, 12'h008, 64'h8000_0000_0000_0000);
    chk_all("R3 enable clear");
    wr(2, 12'h000, 64'h8000_0000_0000_0000);

    // R9: up message and acknowledge of the same slot together
    step(1, 16'd7, 1, 1, {2'd2, 12'h018}, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    chk_all("R9 event beats clear");
    // R4: acknowledge clears
    wr(2, 12'h018, 64'h8000_0000_0000_0000);
    chk_all("R4 status clear");
    // R6: down message retires a level event
    evt(16'd7, 1);
    evt(16'd7, 0);
    chk_all("R6 down clears");

    // R11: remap, and same-cycle message uses old entry
    step(1, 16'd7, 1, 0, 0, 0, 1, 8'd7, 1, 2'd0, 6'd0);
    chk_all("R11 old entry same cycle");
    evt(16'd7, 1);
    chk_all("R11 new entry");
    cfg(8'd7, 0, 2'd0, 6'd0);
    evt(16'd7, 1);
    chk_all("R11 invalidated");

    // R10: writes at unused offsets have no effect
    wr(0, 12'h000, 64'hFFFF_0000_FFFF_0000);
    wr(0, 12'h010, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 12'h020, 64'hFFFF_FFFF_FFFF_FFFF);
    chk_all("R10 unused offsets");

    // random mix
    do_reset();
    for (int i = 0; i < 256; i++)
      if ($urandom_range(0, 3) != 0)
        cfg(i[7:0], 1, 2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)));
    for (int n = 0; n < 3000; n++) begin
      bit ev, we, cw;
      logic [11:0] off;
      logic [63:0] wd;
      int sel;
      ev = ($urandom_range(0, 9) < 6);
      we = ($urandom_range(0, 9) < 3);
      cw = ($urandom_range(0, 19) == 0);
      sel = $urandom_range(0, 4);
      off = (sel == 0) ? 12'h000 : (sel == 1) ? 12'h008 : (sel == 2) ? 12'h018 :
            (sel == 3) ? 12'h010 : 12'h020;
      wd = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      step(ev, 16'($urandom_range(0, 299)), bit'($urandom_range(0, 1)),
           we, {2'($urandom_range(0, 3)), off}, wd,
           cw, 8'($urandom_range(0, 255)), ($urandom_range(0, 4) != 0),
           2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)));
      if (n % 25 == 24) chk_all("R5 R6 random");
    end
    chk_all("R4 R9 random end");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule